// File: doc/BRIEF.md
# Message Readout Unit Packer

This block sits between the one-word message buffer of a paging decoder and the serial path to the host processor. Each time a corrected message codeword lands in the buffer, the block keeps its 20 payload bits (codeword bits 30 down to 11). It then hands them out one readout unit at a time, each time the host asks for a read. The host picks the unit width on every read: 8 data bits, 7 data bits plus one flag bit, or 4 data bits plus a flag nibble. Units run straight on from one word into the next. A unit that starts in one codeword may therefore end in the following one.

The flag in the 7-bit and 4-bit formats warns the host that it should look at the error status. The flag is raised when a unit carries bits from a word whose error grade has reached a programmable limit. It is also raised on the unit that empties the store after the message has ended. Next to the data, the block reports a two-bit error grade for the most recent word, which folds together the BCH error count and the parity error. It also reports an indication that no message data remains, and a sticky overflow flag that is set when a word arrives before the previous one was read out.

Top module: `msg_unit_packer`

## Requirements
- R1: After reset, rd_data is 0x00, err_code is 0, last is 1 and ovfl is 0.
- R2: On each accepted word, err_code takes a new value. It is 0 for no BCH error and no parity error. It is 1 for parity error alone or a single BCH error alone. It is 2 for one BCH error with a parity error, or for two BCH errors without one. It is 3 for two BCH errors with a parity error, or whenever bch_errs is 3.
- R3: With rd_len 00 (8-bit units), each read returns the next 8 payload bits, the earliest in bit 0. Word bit 30 is the earliest of each word and bit 11 the latest. Bits run on across words: the third unit of a word holds its bits 14..11 in bits 3..0 and the next word's bits 30..27 in bits 7..4.
- R4: With rd_len 01 (7-bit units), bits 6..0 hold the next 7 payload bits, the earliest in bit 0, and bit 7 holds the flag. Packing runs across word boundaries.
- R5: With rd_len 10 or 11 (4-bit units), bits 3..0 hold the next 4 payload bits and all four upper bits equal the flag. A single word yields exactly five units.
- R6: With err_limit 00 no unit is flagged for errors. Otherwise a unit is flagged when it contains a bit from a word whose err_code is greater than or equal to err_limit.
- R7: After end of message has been signalled, the read that takes the remaining bits returns them with zeros above. In 7-bit and 4-bit units that read is flagged, even when no bits remain. 8-bit units carry no flag.
- R8: A read that finds fewer bits than the unit width while the message is still open returns 0x00 and consumes nothing.
- R9: When a word arrives while at least one unit of the last read width is still unread, ovfl is set and the unread bits are discarded. The next read starts at bit 30 of the new word. ovfl stays set until msg_start.
- R10: last is 0 from msg_start on and while payload bits remain. It becomes 1 once end of message has been signalled and every bit has been read.
- R11: msg_start discards all stored bits and clears ovfl. The next unit read comes from the next word only.
- R12: rd_data holds its value from one read until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_start | input | 1 | Pulse at the start of a message; clears the store |
| word_valid | input | 1 | Pulse: word_in and its error info are in the buffer |
| word_in | input | 32 | Codeword, bit 31 first on air; payload in bits 30..11 |
| bch_errs | input | 2 | Corrected BCH errors (3 means three or more) |
| par_err | input | 1 | Parity check failed for the word |
| msg_end_in | input | 1 | Pulse: end of message detected |
| err_limit | input | 2 | Error grade at which units are flagged; 00 turns this off |
| rd_req | input | 1 | Read pulse from the host command decoder |
| rd_len | input | 2 | Unit width for this read: 00 eight, 01 seven, 1x four |
| rd_data | output | 8 | Unit returned by the last read |
| err_code | output | 2 | Error grade of the latest word |
| last | output | 1 | No message data left |
| ovfl | output | 1 | A word arrived before the previous one was read out |

## Verification
The bound checker watches the rules that hold on every cycle. It checks the grade of clean words and of words with three or more errors. It checks that the upper nibble of a 4-bit unit is always all zeros or all ones, and that overflow stays set until a new message begins. It also checks that msg_start reopens the store and that rd_data stays still between reads. The exact bit order across word boundaries, the carry of an error flag from a previous word, the padded final unit, stalled reads and the bits that survive an overflow depend on longer histories. Only the bench's scenarios show these, by comparing every unit with a model of the payload bit stream.

// File: rtl/msg_unit_pkg.sv
// Shared definitions for the message readout unit packer.
// Assumes the unit-width code is 00 = 8 bits, 01 = 7 bits, 1x = 4 bits.
package msg_unit_pkg;

    typedef enum logic [1:0] {
        UNIT_8 = 2'b00,
        UNIT_7 = 2'b01,
        UNIT_4 = 2'b10
    } unit_len_e;

    // Number of payload bits a unit-width code takes.
    function automatic logic [3:0] unit_bits(input logic [1:0] code);
        logic [3:0] n;
        case (code)
            2'b00:   n = 4'd8;
            2'b01:   n = 4'd7;
            default: n = 4'd4;
        endcase
        return n;
    endfunction

    // Combined error grade from BCH count and parity failure.
    function automatic logic [1:0] grade(input logic [1:0] bch, input logic par);
        logic [2:0] sum;
        sum = {1'b0, bch} + {2'b00, par};
        if (bch == 2'd3 || sum > 3'd3) return 2'd3;
        return sum[1:0];
    endfunction

endpackage

// File: rtl/mup_err_grade.sv
// Error grading for incoming words.
// Produces the registered grade of the latest word and, combinationally,
// whether the incoming word reaches the programmed flag limit.
// Assumes word_valid is a one-cycle strobe.
module mup_err_grade
    import msg_unit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       word_valid,
    input  logic [1:0] bch_errs,
    input  logic       par_err,
    input  logic [1:0] err_limit,
    output logic [1:0] err_code,
    output logic       new_hot
);

    logic [1:0] grade_now;

    // Grade of the word presented this cycle and its threshold test.
    always_comb begin
        grade_now = grade(bch_errs, par_err);
        new_hot   = (err_limit != 2'b00) && (grade_now >= err_limit);
    end

    // Hold the grade of the most recent word.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_code <= 2'd0;
        else if (word_valid) err_code <= grade_now;
    end

endmodule

// File: rtl/mup_bit_pool.sv
// Payload bit store with read-side extraction.
// Holds the unread payload bits of the current word plus any carried
// leftover of the previous word (fewer than one unit). The newest bit
// is at index 0 and the earliest unread bit at index cnt-1.
// Assumes msg_start, word_valid, msg_end_in and rd_req are strobes.
module mup_bit_pool
    import msg_unit_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int PAY_HI   = 30,
    parameter int PAY_LO   = 11,
    parameter int UNIT_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_start,
    input  logic                word_valid,
    input  logic [WORD_W-1:0]   word_in,
    input  logic                new_hot,
    input  logic                msg_end_in,
    input  logic                rd_req,
    input  logic [1:0]          rd_len,
    output logic [UNIT_MAX-1:0] unit_raw,
    output logic                unit_flag,
    output logic                last,
    output logic                ovfl
);

    localparam int PAY_W  = PAY_HI - PAY_LO + 1;
    localparam int POOL_W = PAY_W + UNIT_MAX - 1;
    localparam int CNT_W  = $clog2(POOL_W + 1);

    logic [POOL_W-1:0] pool_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  carry_q;
    logic              hot_cur_q;
    logic              hot_prev_q;
    logic              ended_q;
    logic              ovfl_q;
    logic [CNT_W-1:0]  len_q;

    logic [CNT_W-1:0]  len_now;
    logic [CNT_W-1:0]  len_eff;
    logic              enough;
    logic              go;
    logic [CNT_W-1:0]  take;
    logic [CNT_W-1:0]  cnt_after;
    logic [CNT_W-1:0]  carry_after;
    logic [PAY_W-1:0]  payload;

    // Decide whether this read consumes bits and how many.
    always_comb begin
        len_now = CNT_W'(unit_bits(rd_len));
        len_eff = rd_req ? len_now : len_q;
        enough  = (cnt_q >= len_now);
        go      = rd_req && (enough || ended_q);
        take    = enough ? len_now : cnt_q;
        payload = word_in[PAY_HI:PAY_LO];
    end

    // Counts left after the read of this cycle.
    always_comb begin
        cnt_after   = go ? (cnt_q - take) : cnt_q;
        carry_after = carry_q;
        if (go) carry_after = (carry_q > take) ? (carry_q - take) : '0;
    end

    // Pick out the unit, earliest bit in position 0, zero above take.
    always_comb begin
        unit_raw = '0;
        for (int k = 0; k < UNIT_MAX; k++) begin
            logic [CNT_W-1:0] idx;
            idx = cnt_q - CNT_W'(k + 1);
            if (go && (CNT_W'(k) < take)) unit_raw[k] = pool_q[idx];
        end
    end

    // Flag: bits from a word over the limit, or the final unit after end.
    always_comb begin
        logic from_prev;
        logic from_cur;
        from_prev = (take != '0) && (carry_q != '0) && hot_prev_q;
        from_cur  = (take > carry_q) && hot_cur_q;
        unit_flag = go && (from_prev || from_cur || (ended_q && (cnt_q <= len_now)));
    end

    // Store update: message start, reads, word arrival and overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_q     <= '0;
            cnt_q      <= '0;
            carry_q    <= '0;
            hot_cur_q  <= 1'b0;
            hot_prev_q <= 1'b0;
            ended_q    <= 1'b1;
            ovfl_q     <= 1'b0;
            len_q      <= CNT_W'(8);
        end else if (msg_start) begin
            cnt_q      <= '0;
            carry_q    <= '0;
            hot_cur_q  <= 1'b0;
            hot_prev_q <= 1'b0;
            ended_q    <= 1'b0;
            ovfl_q     <= 1'b0;
        end else begin
            if (rd_req) len_q <= len_now;
            if (word_valid) begin
                hot_cur_q <= new_hot;
                ended_q   <= msg_end_in;
                if (cnt_after >= len_eff) begin
                    ovfl_q     <= 1'b1;
                    pool_q     <= POOL_W'(payload);
                    cnt_q      <= CNT_W'(PAY_W);
                    carry_q    <= '0;
                    hot_prev_q <= 1'b0;
                end else begin
                    pool_q     <= {pool_q[POOL_W-PAY_W-1:0], payload};
                    cnt_q      <= cnt_after + CNT_W'(PAY_W);
                    carry_q    <= cnt_after;
                    hot_prev_q <= hot_cur_q;
                end
            end else begin
                cnt_q   <= cnt_after;
                carry_q <= carry_after;
                if (msg_end_in) ended_q <= 1'b1;
            end
        end
    end

    assign last = ended_q && (cnt_q == '0);
    assign ovfl = ovfl_q;

endmodule

// File: rtl/mup_unit_fmt.sv
// Output formatting of one readout unit.
// Places the flag into bit 7 (7-bit units) or bits 7..4 (4-bit units)
// and registers the byte on each read. Assumes raw is zero above the
// unit width.
module mup_unit_fmt
    import msg_unit_pkg::*;
#(
    parameter int UNIT_MAX = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic [1:0]          rd_len,
    input  logic [UNIT_MAX-1:0] raw,
    input  logic                flag,
    output logic [UNIT_MAX-1:0] rd_data
);

    logic [UNIT_MAX-1:0] shaped;

    // Merge flag bits according to the unit width.
    always_comb begin
        case (rd_len)
            UNIT_8:  shaped = raw;
            UNIT_7:  shaped = {flag, raw[UNIT_MAX-2:0]};
            default: shaped = {{(UNIT_MAX-4){flag}}, raw[3:0]};
        endcase
    end

    // Capture the unit when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= shaped;
    end

endmodule

// File: rtl/msg_unit_packer.sv
// Top of the message readout unit packer.
// Grades each incoming word, stores its payload bits and serves them in
// 8, 7 or 4 bit units with status flags. Assumes a synchronous reset
// and single-cycle strobes on all control inputs.
module msg_unit_packer
    import msg_unit_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int PAY_HI   = 30,
    parameter int PAY_LO   = 11,
    parameter int UNIT_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_start,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic [1:0]        bch_errs,
    input  logic              par_err,
    input  logic              msg_end_in,
    input  logic [1:0]        err_limit,
    input  logic              rd_req,
    input  logic [1:0]        rd_len,
    output logic [7:0]        rd_data,
    output logic [1:0]        err_code,
    output logic              last,
    output logic              ovfl
);

    logic                new_hot;
    logic [UNIT_MAX-1:0] unit_raw;
    logic                unit_flag;

    mup_err_grade u_grade (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_valid(word_valid),
        .bch_errs  (bch_errs),
        .par_err   (par_err),
        .err_limit (err_limit),
        .err_code  (err_code),
        .new_hot   (new_hot)
    );

    mup_bit_pool #(
        .WORD_W  (WORD_W),
        .PAY_HI  (PAY_HI),
        .PAY_LO  (PAY_LO),
        .UNIT_MAX(UNIT_MAX)
    ) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_start (msg_start),
        .word_valid(word_valid),
        .word_in   (word_in),
        .new_hot   (new_hot),
        .msg_end_in(msg_end_in),
        .rd_req    (rd_req),
        .rd_len    (rd_len),
        .unit_raw  (unit_raw),
        .unit_flag (unit_flag),
        .last      (last),
        .ovfl      (ovfl)
    );

    mup_unit_fmt #(
        .UNIT_MAX(UNIT_MAX)
    ) u_fmt (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (rd_req),
        .rd_len (rd_len),
        .raw    (unit_raw),
        .flag   (unit_flag),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/msg_unit_packer_chk.sv
// Cycle-level rules of the message readout unit packer, bound to the top.
module msg_unit_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msg_start,
    input logic        word_valid,
    input logic [31:0] word_in,
    input logic [1:0]  bch_errs,
    input logic        par_err,
    input logic        msg_end_in,
    input logic [1:0]  err_limit,
    input logic        rd_req,
    input logic [1:0]  rd_len,
    input logic [7:0]  rd_data,
    input logic [1:0]  err_code,
    input logic        last,
    input logic        ovfl
);

    a_r2_clean_grade: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && bch_errs == 2'd0 && !par_err) |=> (err_code == 2'd0));

    a_r2_severe_grade: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && bch_errs == 2'd3) |=> (err_code == 2'd3));

    a_r5_nibble_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_len[1]) |=> (rd_data[7:4] == 4'h0 || rd_data[7:4] == 4'hF));

    a_r9_ovfl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovfl && !msg_start) |=> ovfl);

    a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        msg_start |=> (!ovfl && !last));

    a_r12_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

endmodule

bind msg_unit_packer msg_unit_packer_chk u_chk (.*);

// File: tb/msg_unit_packer_test.sv
`timescale 1ns/1ps
// Scoreboard bench: read tasks push expected units, a monitor compares.
module msg_unit_packer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_start = 1'b0;
    logic        word_valid = 1'b0;
    logic [31:0] word_in = '0;
    logic [1:0]  bch_errs = '0;
    logic        par_err = 1'b0;
    logic        msg_end_in = 1'b0;
    logic [1:0]  err_limit = '0;
    logic        rd_req = 1'b0;
    logic [1:0]  rd_len = '0;
    logic [7:0]  rd_data;
    logic [1:0]  err_code;
    logic        last;
    logic        ovfl;

    msg_unit_packer uut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model: each entry is {payload bit, word over limit}.
    logic [1:0]  mq[$];
    bit          m_end = 1'b1;
    bit          m_ovfl = 1'b0;
    int          m_len = 8;
    logic [7:0]  last_exp = 8'h00;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_grade(input logic [1:0] b, input logic p);
        case ({b, p})
            3'b000: return 2'd0;
            3'b001: return 2'd1;
            3'b010: return 2'd1;
            3'b011: return 2'd2;
            3'b100: return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Monitor: compare each unit one cycle after its read strobe.
    initial begin
        bit pend = 1'b0;
        forever begin
            @(negedge clk);
            if (pend) begin
                string t;
                logic [7:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {24'd0, rd_data}, {24'd0, e});
            end
            pend = rd_req;
        end
    end

    task automatic do_read(input logic [1:0] len, input string tag);
        int n;
        logic [7:0] b;
        logic flag;
        int sz;
        n = (len == 2'b00) ? 8 : (len == 2'b01) ? 7 : 4;
        m_len = n;
        b = 8'h00;
        flag = 1'b0;
        sz = mq.size();
        if (sz >= n || m_end) begin
            int take;
            take = (sz >= n) ? n : sz;
            for (int k = 0; k < take; k++) begin
                logic [1:0] e;
                e = mq.pop_front();
                b[k] = e[1];
                flag |= e[0];
            end
            if (m_end && sz <= n) flag = 1'b1;
            if (n == 7) b[7] = flag;
            if (n == 4) b[7:4] = {4{flag}};
        end
        last_exp = b;
        exp_q.push_back(b);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_req = 1'b1; rd_len = len;
        @(posedge clk); #1;
        rd_req = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w, input logic [1:0] b, input logic p);
        logic hot;
        logic [1:0] g;
        g = exp_grade(b, p);
        hot = (err_limit != 2'b00) && (g >= err_limit);
        if (mq.size() >= m_len) begin
            m_ovfl = 1'b1;
            mq.delete();
        end
        for (int i = 30; i >= 11; i--) mq.push_back({w[i], hot});
        m_end = 1'b0;
        @(posedge clk); #1;
        word_valid = 1'b1; word_in = w; bch_errs = b; par_err = p;
        @(posedge clk); #1;
        word_valid = 1'b0;
        check("R2 grade", {30'd0, err_code}, {30'd0, g});
    endtask

    task automatic pulse_end();
        m_end = 1'b1;
        @(posedge clk); #1; msg_end_in = 1'b1;
        @(posedge clk); #1; msg_end_in = 1'b0;
    endtask

    task automatic pulse_start();
        mq.delete();
        m_end = 1'b0;
        m_ovfl = 1'b0;
        @(posedge clk); #1; msg_start = 1'b1;
        @(posedge clk); #1; msg_start = 1'b0;
    endtask

    task automatic drain();
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 data", {24'd0, rd_data}, 32'd0);
        check("R1 grade", {30'd0, err_code}, 32'd0);
        check("R1 last", {31'd0, last}, 32'd1);
        check("R1 ovfl", {31'd0, ovfl}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R3 and R8: 8-bit units running across words, stall on short store.
        pulse_start();
        check("R10 open after start", {31'd0, last}, 32'd0);
        err_limit = 2'b00;
        send_word(32'h5A3C_9E81, 2'd0, 1'b0);
        do_read(2'b00, "R3 byte0");
        do_read(2'b00, "R3 byte1");
        do_read(2'b00, "R8 stall");
        drain();
        send_word(32'hC3A5_6F17, 2'd0, 1'b1);
        check("R9 no ovfl", {31'd0, ovfl}, 32'd0);
        do_read(2'b00, "R3 spanning byte");
        do_read(2'b00, "R3 byte");
        do_read(2'b00, "R3 byte");
        drain();
        repeat (3) @(posedge clk);
        #1;
        check("R12 hold", {24'd0, rd_data}, {24'd0, last_exp});

        // R4 and R6: 7-bit units with an error limit and carried flag.
        pulse_start();
        err_limit = 2'b10;
        send_word(32'h2B6D_F0A5, 2'd1, 1'b1);
        do_read(2'b01, "R4 unit");
        do_read(2'b01, "R4 unit");
        drain();
        send_word(32'h9187_3CE4, 2'd0, 1'b1);
        do_read(2'b01, "R6 flag from carried bits");
        do_read(2'b01, "R6 no flag");
        do_read(2'b01, "R4 unit");
        do_read(2'b01, "R8 stall 7");
        drain();
        pulse_end();
        check("R10 not last yet", {31'd0, last}, 32'd0);
        do_read(2'b01, "R7 padded final");
        drain();
        check("R10 last", {31'd0, last}, 32'd1);

        // R5 and R6: 4-bit units, limit off, end flag on last unit.
        pulse_start();
        err_limit = 2'b00;
        send_word(32'h7E1B_4D29, 2'd2, 1'b1);
        do_read(2'b10, "R5 nibble");
        do_read(2'b11, "R5 nibble");
        do_read(2'b10, "R6 limit off");
        do_read(2'b10, "R5 nibble");
        drain();
        pulse_end();
        do_read(2'b10, "R7 final nibble");
        do_read(2'b10, "R7 empty after end");
        drain();
        check("R10 last 4", {31'd0, last}, 32'd1);

        // R2 remaining grades.
        pulse_start();
        err_limit = 2'b01;
        send_word(32'h0000_0800, 2'd1, 1'b0);
        send_word(32'h0000_0800, 2'd2, 1'b0);
        send_word(32'h0000_0800, 2'd3, 1'b0);

        // R9: overflow and recovery; R11: start discards residue.
        pulse_start();
        err_limit = 2'b00;
        do_read(2'b00, "R8 empty stall");
        send_word(32'h1F2E_3D4C, 2'd0, 1'b0);
        do_read(2'b00, "R3 byte");
        drain();
        send_word(32'hE6D5_C4B3, 2'd0, 1'b0);
        check("R9 ovfl set", {31'd0, ovfl}, 32'd1);
        do_read(2'b00, "R9 new word first");
        drain();
        check("R9 ovfl held", {31'd0, ovfl}, 32'd1);
        pulse_start();
        check("R11 ovfl cleared", {31'd0, ovfl}, 32'd0);
        send_word(32'hA55A_F00F, 2'd0, 1'b0);
        do_read(2'b00, "R3 byte");
        drain();
        pulse_start();
        send_word(32'h3C3C_C3C3, 2'd0, 1'b0);
        do_read(2'b00, "R11 fresh word");
        drain();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule